// File: doc/BRIEF.md
# Direct-Mapped Cache with Deferred Store Buffer

This block is a small direct-mapped data cache whose store path is pipelined so that a store costs the processor no more cycles than a load. A store looks up the tag in its request cycle, just as a load does. If the store hits, the word, its byte enables and its location are parked in a single-entry pending slot rather than being written into the data array at once. The data array is then updated later, in a cycle in which no load needs the array's single port. A load that targets the parked word receives the array word with the parked bytes merged over it, so a load issued in the cycle right after a store still sees the new value.

Misses are reported and then stall the processor port. The block drops its ready output and waits until an outside agent installs a full line through the fill port. The fill port is accepted only when no store is pending and no processor request is being taken. This keeps a line install from racing a deferred store into the same array.

The default configuration is a 1 KB cache with 16-byte lines, 32-bit words and 16-bit byte addresses. That gives 64 lines of four words each.

Top module: `dwb_cache`

## Requirements
- R1: While reset is held and right after it, rsp_valid is 0 and cpu_ready is 1; every line starts invalid, so the first access to any address misses.
- R2: A request is accepted in a cycle where req_valid and cpu_ready are both 1. Its response (rsp_valid=1, rsp_hit) appears after the next rising edge. The address is split as: byte in word bits [1:0], word in line bits [3:2], line index bits [9:4], tag bits [15:10]. A load hit returns word w of the installed line, which is fill_line[32w+31:32w].
- R3: A store hit responds with rsp_hit=1 and leaves cpu_ready at 1. Later loads of that word see byte b replaced by req_wdata[8b+7:8b] wherever req_be[b] is 1, and unchanged elsewhere.
- R4: A load of the same word in the cycle right after a store hit returns the merged value from R3, with no extra cycle.
- R5: Stores hit in consecutive cycles, including two stores to the same word, are all accepted without a stall, and each one takes effect in order.
- R6: The pending store retires in the first cycle with no accepted load. fill_ready is 1 only when no store is pending and no request is being accepted. After a store followed by loads, the first idle cycle still shows fill_ready=0, and the next idle cycle shows 1.
- R7: A store miss gives rsp_hit=0 and cpu_ready=0 from the next cycle. It creates no pending entry, so fill_ready is 1 in the following idle cycle, and it writes no data.
- R8: A load miss gives rsp_hit=0 and cpu_ready=0 from the next cycle. Requests offered while cpu_ready is 0 produce no response and change no data.
- R9: A fill is taken in a cycle with fill_valid and fill_ready both 1. It installs the tag and line selected by fill_addr, and cpu_ready is 1 after that edge.
- R10: rsp_rdata is zero in the response to a store and in the response to any miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| cpu_ready | output | 1 | 0 while stalled on a miss |
| rsp_valid | output | 1 | Response to the request accepted in the previous cycle |
| rsp_hit | output | 1 | That request hit |
| rsp_rdata | output | 32 | Load data (zero for stores and misses) |
| fill_valid | input | 1 | Line install offered |
| fill_addr | input | 16 | Address whose tag and index select the line |
| fill_line | input | 128 | Whole line, word 0 in the low bits |
| fill_ready | output | 1 | Fill can be taken this cycle |

## Verification
Each response is due exactly one rising edge after its request is accepted. The bench therefore drives on the falling edge and reads rsp_valid, rsp_hit, rsp_rdata and cpu_ready just after the following rising edge.

fill_ready depends on the current request as well as on the pending slot, so it is only sampled in idle cycles, a moment after the falling edge. This is what shows that the slot survives loads and drains one idle cycle later.

The forwarding check pairs every word of the cache with a load one cycle after its store, cycling through all sixteen byte-enable patterns. A reference word image decides every expected value.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;

  // byte-wise overlay of upd onto base where be is set
  function automatic logic [WORD_W-1:0] merge_bytes(input logic [WORD_W-1:0] base,
                                                    input logic [WORD_W-1:0] upd,
                                                    input logic [BE_W-1:0]   be);
    logic [WORD_W-1:0] r;
    r = base;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) r[8*b +: 8] = upd[8*b +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/dwb_tag_store.sv
module dwb_tag_store #(
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = 6,
  parameter int TAG_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             inst_en,
  input  logic [IDX_W-1:0] inst_idx,
  input  logic [TAG_W-1:0] inst_tag
);
  logic [NUM_LINES-1:0] vld_q, vld_d;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  always_comb begin
    vld_d = vld_q;
    if (inst_en) vld_d[inst_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (inst_en) tag_q[inst_idx] <= inst_tag;
  end

  assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/dwb_data_store.sv
module dwb_data_store
  import dwb_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int WPL       = 4,
  parameter int IDX_W     = 6,
  parameter int WSEL_W    = 2
) (
  input  logic                  clk,
  input  logic [IDX_W-1:0]      rd_idx,
  input  logic [WSEL_W-1:0]     rd_wsel,
  output logic [WORD_W-1:0]     rd_word,
  input  logic                  line_we,
  input  logic [IDX_W-1:0]      line_idx,
  input  logic [WPL*WORD_W-1:0] line_data,
  input  logic                  word_we,
  input  logic [IDX_W-1:0]      word_idx,
  input  logic [WSEL_W-1:0]     word_wsel,
  input  logic [BE_W-1:0]       word_be,
  input  logic [WORD_W-1:0]     word_data
);
  logic [WORD_W-1:0] lane_q [WPL];

  // one storage lane per word position; a line install writes all lanes,
  // a retiring store writes the bytes of one lane
  for (genvar w = 0; w < WPL; w++) begin : g_lane
    logic [WORD_W-1:0] mem [NUM_LINES];
    logic [BE_W-1:0]   we_b;
    logic [IDX_W-1:0]  widx;
    logic [WORD_W-1:0] wdat;

    always_comb begin
      if (line_we) begin
        we_b = '1;
        widx = line_idx;
        wdat = line_data[w*WORD_W +: WORD_W];
      end else begin
        we_b = (word_we && (word_wsel == WSEL_W'(w))) ? word_be : '0;
        widx = word_idx;
        wdat = word_data;
      end
    end

    always_ff @(posedge clk) begin
      for (int b = 0; b < BE_W; b++) begin
        if (we_b[b]) mem[widx][8*b +: 8] <= wdat[8*b +: 8];
      end
    end

    assign lane_q[w] = mem[rd_idx];
  end

  assign rd_word = lane_q[rd_wsel];
endmodule

// File: rtl/dwb_pend_buf.sv
module dwb_pend_buf
  import dwb_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [WSEL_W-1:0] ld_wsel,
  input  logic [BE_W-1:0]   ld_be,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              rd_cycle,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [WSEL_W-1:0] lk_wsel,
  output logic              lk_match,
  output logic              q_valid,
  output logic [IDX_W-1:0]  q_idx,
  output logic [WSEL_W-1:0] q_wsel,
  output logic [BE_W-1:0]   q_be,
  output logic [WORD_W-1:0] q_data,
  output logic              commit
);
  logic              valid_d;
  logic [IDX_W-1:0]  idx_d;
  logic [WSEL_W-1:0] wsel_d;
  logic [BE_W-1:0]   be_d;
  logic [WORD_W-1:0] data_d;

  // the array port is free in any cycle without an accepted load
  assign commit   = q_valid && !rd_cycle;
  assign lk_match = q_valid && (q_idx == lk_idx) && (q_wsel == lk_wsel);

  always_comb begin
    valid_d = q_valid;
    if (ld_en)       valid_d = 1'b1;
    else if (commit) valid_d = 1'b0;
    idx_d  = ld_en ? ld_idx  : q_idx;
    wsel_d = ld_en ? ld_wsel : q_wsel;
    be_d   = ld_en ? ld_be   : q_be;
    data_d = ld_en ? ld_data : q_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_idx   <= '0;
      q_wsel  <= '0;
      q_be    <= '0;
      q_data  <= '0;
    end else begin
      q_valid <= valid_d;
      q_idx   <= idx_d;
      q_wsel  <= wsel_d;
      q_be    <= be_d;
      q_data  <= data_d;
    end
  end
endmodule

// File: rtl/dwb_cache.sv
module dwb_cache
  import dwb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LINE_BYTES  = 16,
  parameter int CACHE_BYTES = 1024
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_we,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  input  logic [BE_W-1:0]         req_be,
  output logic                    cpu_ready,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic [WORD_W-1:0]       rsp_rdata,
  input  logic                    fill_valid,
  input  logic [ADDR_W-1:0]       fill_addr,
  input  logic [LINE_BYTES*8-1:0] fill_line,
  output logic                    fill_ready
);
  localparam int WPL       = LINE_BYTES / BE_W;
  localparam int NUM_LINES = CACHE_BYTES / LINE_BYTES;
  localparam int BOFS_W    = $clog2(BE_W);
  localparam int WSEL_W    = $clog2(WPL);
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int LOW_W     = BOFS_W + WSEL_W;
  localparam int TAG_W     = ADDR_W - IDX_W - LOW_W;

  // address fields
  logic [TAG_W-1:0]  r_tag, f_tag;
  logic [IDX_W-1:0]  r_idx, f_idx;
  logic [WSEL_W-1:0] r_wsel;
  logic              unused_lsbs;

  assign r_tag       = req_addr[ADDR_W-1 -: TAG_W];
  assign r_idx       = req_addr[LOW_W +: IDX_W];
  assign r_wsel      = req_addr[BOFS_W +: WSEL_W];
  assign f_tag       = fill_addr[ADDR_W-1 -: TAG_W];
  assign f_idx       = fill_addr[LOW_W +: IDX_W];
  assign unused_lsbs = ^{req_addr[BOFS_W-1:0], fill_addr[LOW_W-1:0]};

  // request qualification
  logic stall_q, stall_d;
  logic acc, req_rd, req_wr, lk_hit, fill_go;

  assign cpu_ready  = !stall_q;
  assign acc        = req_valid && cpu_ready;
  assign req_rd     = acc && !req_we;
  assign req_wr     = acc && req_we;

  // pending-store slot
  logic              pb_valid, pb_match, pb_commit;
  logic [IDX_W-1:0]  pb_idx;
  logic [WSEL_W-1:0] pb_wsel;
  logic [BE_W-1:0]   pb_be;
  logic [WORD_W-1:0] pb_data;

  assign fill_ready = !pb_valid && !acc;
  assign fill_go    = fill_valid && fill_ready;

  dwb_tag_store #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W),
    .TAG_W     (TAG_W)
  ) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (r_idx),
    .lk_tag   (r_tag),
    .lk_hit   (lk_hit),
    .inst_en  (fill_go),
    .inst_idx (f_idx),
    .inst_tag (f_tag)
  );

  logic [WORD_W-1:0] arr_word;

  dwb_data_store #(
    .NUM_LINES (NUM_LINES),
    .WPL       (WPL),
    .IDX_W     (IDX_W),
    .WSEL_W    (WSEL_W)
  ) u_data (
    .clk       (clk),
    .rd_idx    (r_idx),
    .rd_wsel   (r_wsel),
    .rd_word   (arr_word),
    .line_we   (fill_go),
    .line_idx  (f_idx),
    .line_data (fill_line),
    .word_we   (pb_commit),
    .word_idx  (pb_idx),
    .word_wsel (pb_wsel),
    .word_be   (pb_be),
    .word_data (pb_data)
  );

  dwb_pend_buf #(
    .IDX_W  (IDX_W),
    .WSEL_W (WSEL_W)
  ) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (req_wr && lk_hit),
    .ld_idx   (r_idx),
    .ld_wsel  (r_wsel),
    .ld_be    (req_be),
    .ld_data  (req_wdata),
    .rd_cycle (req_rd),
    .lk_idx   (r_idx),
    .lk_wsel  (r_wsel),
    .lk_match (pb_match),
    .q_valid  (pb_valid),
    .q_idx    (pb_idx),
    .q_wsel   (pb_wsel),
    .q_be     (pb_be),
    .q_data   (pb_data),
    .commit   (pb_commit)
  );

  // load data with forwarding from the pending slot
  logic [WORD_W-1:0] ld_word;
  assign ld_word = pb_match ? merge_bytes(arr_word, pb_data, pb_be) : arr_word;

  // response stage: next state
  logic              rsp_valid_d, rsp_hit_d;
  logic [WORD_W-1:0] rsp_rdata_d;
  logic              rdata_en;

  always_comb begin
    rsp_valid_d = acc;
    rsp_hit_d   = acc && lk_hit;
    rdata_en    = acc;
    rsp_rdata_d = (req_rd && lk_hit) ? ld_word : '0;
    stall_d     = stall_q;
    if (fill_go)              stall_d = 1'b0;
    else if (acc && !lk_hit)  stall_d = 1'b1;
  end

  // response stage: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      stall_q   <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_hit   <= rsp_hit_d;
      stall_q   <= stall_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rsp_rdata <= '0;
    else if (rdata_en) rsp_rdata <= rsp_rdata_d;
  end
endmodule

// File: rtl/dwb_cache_chk.sv
module dwb_cache_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic cpu_ready,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic fill_valid,
  input logic fill_ready
);
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (!rsp_valid && cpu_ready));

  p_hit_no_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> cpu_ready);

  p_idle_drains_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (req_valid || fill_ready));

  p_miss_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> !cpu_ready);

  p_stalled_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |=> !rsp_valid);

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ready && !(fill_valid && fill_ready)) |=> !cpu_ready);

  p_fill_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> cpu_ready);
endmodule

bind dwb_cache dwb_cache_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .cpu_ready  (cpu_ready),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .fill_valid (fill_valid),
  .fill_ready (fill_ready)
);

// File: tb/dwb_cache_bench.sv
module dwb_cache_bench;
  logic         clk, rst_n;
  logic         req_valid, req_we;
  logic [15:0]  req_addr;
  logic [31:0]  req_wdata;
  logic [3:0]   req_be;
  logic         cpu_ready, rsp_valid, rsp_hit;
  logic [31:0]  rsp_rdata;
  logic         fill_valid;
  logic [15:0]  fill_addr;
  logic [127:0] fill_line;
  logic         fill_ready;

  dwb_cache u_dwb_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .cpu_ready(cpu_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_rdata(rsp_rdata), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_line(fill_line), .fill_ready(fill_ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int n_tests = 0;
  int n_fail  = 0;

  // reference image
  logic [31:0] m_data [256];
  logic [5:0]  m_tag  [64];
  bit          m_val  [64];

  function automatic logic [15:0] mk(input int tag, input int idx, input int w);
    return 16'((tag << 10) | (idx << 4) | (w << 2));
  endfunction

  function automatic logic [31:0] pat(input int tag, input int idx, input int w);
    return 32'h9E3779B9 * 32'(tag * 256 + idx * 4 + w + 1) + 32'(idx);
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic idle_chk(input int want_fr, input string what);
    @(negedge clk);
    req_valid = 1'b0;
    fill_valid = 1'b0;
    #1;
    if (want_fr >= 0) chk(fill_ready == want_fr[0], what, 32'(fill_ready), 32'(want_fr));
    @(posedge clk); #1;
  endtask

  // one accepted request, checked after the next rising edge
  task automatic access(input bit we, input logic [15:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input string what);
    int idx, w, tg;
    bit exp_hit;
    logic [31:0] cur;
    idx = int'(a[9:4]); w = int'(a[3:2]); tg = int'(a[15:10]);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd; req_be = be;
    exp_hit = m_val[idx] && (int'(m_tag[idx]) == tg);
    @(posedge clk); #1;
    chk(rsp_valid == 1'b1, {what, " R2 rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk(rsp_hit == exp_hit, {what, " hit"}, 32'(rsp_hit), 32'(exp_hit));
    if (exp_hit) begin
      chk(cpu_ready == 1'b1, {what, " R5 ready on hit"}, 32'(cpu_ready), 32'd1);
      if (!we) chk(rsp_rdata == m_data[idx*4+w], {what, " data"}, rsp_rdata, m_data[idx*4+w]);
      else begin
        chk(rsp_rdata == 32'd0, {what, " R10 store rdata"}, rsp_rdata, 32'd0);
        cur = m_data[idx*4+w];
        for (int b = 0; b < 4; b++) if (be[b]) cur[8*b +: 8] = wd[8*b +: 8];
        m_data[idx*4+w] = cur;
      end
    end else begin
      chk(cpu_ready == 1'b0, {what, " R7/R8 stall on miss"}, 32'(cpu_ready), 32'd0);
      chk(rsp_rdata == 32'd0, {what, " R10 miss rdata"}, rsp_rdata, 32'd0);
    end
  endtask

  task automatic fill(input int tg, input int idx, input string what);
    @(negedge clk);
    req_valid = 1'b0;
    fill_valid = 1'b1;
    fill_addr = mk(tg, idx, 0);
    for (int w = 0; w < 4; w++) fill_line[32*w +: 32] = pat(tg, idx, w);
    #1;
    while (!fill_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    m_val[idx] = 1'b1;
    m_tag[idx] = 6'(tg);
    for (int w = 0; w < 4; w++) m_data[idx*4+w] = pat(tg, idx, w);
    chk(cpu_ready == 1'b1, {what, " R9 ready after fill"}, 32'(cpu_ready), 32'd1);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic offer_stalled(input logic [15:0] a, input string what);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = 32'hDEADBEEF; req_be = 4'hF;
    @(posedge clk); #1;
    chk(rsp_valid == 1'b0, {what, " R8 no response while stalled"}, 32'(rsp_valid), 32'd0);
  endtask

  function automatic int tag_of(input int idx);
    return (idx ^ 21) & 63;
  endfunction

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    req_be = '0; fill_valid = 1'b0; fill_addr = '0; fill_line = '0;
    for (int i = 0; i < 64; i++) begin m_val[i] = 1'b0; m_tag[i] = '0; end
    for (int i = 0; i < 256; i++) m_data[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk(cpu_ready == 1'b1, "R1 cpu_ready in reset", 32'(cpu_ready), 32'd1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(rsp_valid == 1'b0 && cpu_ready == 1'b1, "R1 after release", {rsp_valid, cpu_ready}, 32'd1);

    // R1/R8: first access misses, then offers while stalled are ignored
    access(1'b0, mk(tag_of(0), 0, 0), '0, '0, "R1 R8 cold load");
    offer_stalled(mk(tag_of(1), 1, 0), "cold");
    offer_stalled(mk(tag_of(1), 1, 0), "cold");

    // R9: install every line
    for (int i = 0; i < 64; i++) fill(tag_of(i), i, "R9 fill");
    idle_chk(1, "R6 idle after fills");

    // R2: sweep every word with loads, back to back
    for (int i = 0; i < 256; i++) access(1'b0, mk(tag_of(i/4), i/4, i%4), '0, '0, "R2 load sweep");
    idle_chk(-1, "");

    // R5/R3: back-to-back stores over every word, then a double store to one word
    for (int i = 0; i < 256; i++)
      access(1'b1, mk(tag_of(i/4), i/4, i%4), 32'hA5000000 ^ (32'(i) * 32'h01010101), 4'hF, "R5 store sweep");
    access(1'b1, mk(tag_of(9), 9, 2), 32'h11223344, 4'hF, "R5 same word 1");
    access(1'b1, mk(tag_of(9), 9, 2), 32'h55667788, 4'h6, "R5 same word 2");
    idle_chk(-1, "");
    for (int i = 0; i < 256; i++) access(1'b0, mk(tag_of(i/4), i/4, i%4), '0, '0, "R3 R5 readback");
    idle_chk(-1, "");

    // R4/R3: store then load of same word next cycle, all byte-enable patterns
    for (int i = 0; i < 256; i++) begin
      access(1'b1, mk(tag_of(i/4), i/4, i%4), 32'h3C5A0000 + 32'(i * 7919), 4'(i % 16), "R3 partial store");
      access(1'b0, mk(tag_of(i/4), i/4, i%4), '0, '0, "R4 forwarded load");
    end
    idle_chk(-1, "");

    // R6: store, loads, then two idle cycles
    access(1'b1, mk(tag_of(3), 3, 1), 32'hCAFEF00D, 4'hF, "R6 store");
    access(1'b0, mk(tag_of(4), 4, 0), '0, '0, "R6 load 1");
    access(1'b0, mk(tag_of(3), 3, 1), '0, '0, "R6 R4 load 2");
    idle_chk(0, "R6 slot held through loads");
    idle_chk(1, "R6 slot drained");
    access(1'b1, mk(tag_of(7), 7, 3), 32'h0BADCAFE, 4'hF, "R6 store b");
    idle_chk(0, "R6 pending during first idle");
    idle_chk(1, "R6 empty after idle");

    // R7: store miss, no pending entry, no data written
    access(1'b1, mk(tag_of(5) ^ 1, 5, 2), 32'hFFFFFFFF, 4'hF, "R7 store miss");
    idle_chk(1, "R7 no pending entry");
    offer_stalled(mk(tag_of(6), 6, 0), "R7");
    fill(tag_of(5) ^ 1, 5, "R7 refill");
    access(1'b0, mk(tag_of(5) ^ 1, 5, 2), '0, '0, "R7 line holds fill data");
    access(1'b0, mk(tag_of(6), 6, 0), '0, '0, "R8 stalled store had no effect");

    // R8: load miss to a replaced tag
    access(1'b0, mk(tag_of(5), 5, 0), '0, '0, "R8 load miss");
    offer_stalled(mk(tag_of(5), 5, 0), "R8");
    fill(tag_of(5), 5, "R9 refill back");
    access(1'b0, mk(tag_of(5), 5, 3), '0, '0, "R9 load after refill");
    idle_chk(-1, "");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule